// File: doc/BRIEF.md
# Sub-clock interval watch timer

This block is a free-running 15-bit counter that advances on every tick of a slow sub clock. The sub clock reaches it as a single-cycle enable, `sub_tick`, sampled in the system clock domain. The counter serves two purposes. It drives an interval flag through one of four selectable counter bits, and it exposes its full value on a dedicated output so that a watchdog elsewhere can take its timing from the taps.

Software reaches an 8-bit control register and the counter through a small synchronous bus. Writes take effect at the clock edge where `wr_en` is high, and reads are combinational on `addr`. The control register holds the following fields:

- a two-bit interval select,
- an interrupt enable,
- a clear request bit that is active low,
- a sticky overflow flag.

An interrupt request is raised while the flag and the enable are both set. The counter returns to zero on power-on reset, while the stop-mode entry signal is high, and on a software clear.

Top module: `subclk_watch_timer`

## Requirements
- R1: On each clock edge with `sub_tick` high, `stop_req` low and no pending clear, the counter increments by one and wraps modulo 2^15. A read with `addr`=1 returns the counter in `rdata[14:0]`, and `rdata[15]` reads 0.
- R2: After reset the counter is 0, `irq` is 0, and the control register (read with `addr`=0) returns 0x08. Its layout is: bits [1:0] interval select, bit 2 interrupt enable, bit 3 clear bit, bit 4 flag, and all other bits 0.
- R3: While `stop_req` is high the counter is forced to 0 at every clock edge, whatever `sub_tick` does.
- R4: A control write with bit 3 equal to 0 requests a clear. Bit 3 then reads 0 and the counter does not change until the next edge with `sub_tick` high. At that edge the counter becomes 0 instead of incrementing, and bit 3 reads 1 again.
- R5: The interval select picks the flag source: 0 selects counter bit 7, 1 selects bit 9, 2 selects bit 11, and 3 selects bit 14. The flag (bit 4) is set at the tick on which the selected bit changes from 0 to 1.
- R6: The flag is sticky. A control write with bit 4 equal to 0 clears it, and a write with bit 4 equal to 1 leaves it unchanged.
- R7: When a flag set event and a write clearing the flag fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when both the flag and the interrupt enable (bit 2) are 1. The select and enable bits read back as written.
- R9: `wdog_count` always equals the counter value returned by a counter read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sub_tick | input | 1 | One-cycle pulse per sub-clock tick |
| stop_req | input | 1 | Stop-mode entry; holds the counter at zero |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the control register, 1 selects the counter |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | Interval interrupt request |
| wdog_count | output | 15 | Counter value exported as watchdog taps |

## Verification
The assertions assume that `sub_tick` is already a clean, single-cycle pulse synchronous to `clk`. They also assume that `stop_req` is a synchronous level, and that a write to the control register does not also request a clear while `stop_req` is high. The stimulus drives every input on the falling edge of `clk` only, and keeps stop mode apart from register writes. Ticks are issued in bursts of exact length, so each tap crossing falls on a tick count known in advance. The bench also places a flag-clearing write on the very tick that produces a tap rise.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int CNT_W  = 15;
  localparam int REG_W  = 8;
  localparam int B_SEL0 = 0;
  localparam int B_SEL1 = 1;
  localparam int B_IE   = 2;
  localparam int B_CLR  = 3;
  localparam int B_FLAG = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  // Counter bit chosen by the two-bit interval select
  function automatic int tap_index(input logic [1:0] sel,
                                   input int t0, input int t1,
                                   input int t2, input int t3);
    case (sel)
      2'd0:    return t0;
      2'd1:    return t1;
      2'd2:    return t2;
      default: return t3;
    endcase
  endfunction

  // True when incrementing cur turns bit idx from 0 to 1
  function automatic logic bit_rises(input cnt_t cur, input int idx);
    cnt_t nxt;
    nxt = cur + cnt_t'(1);
    return !cur[idx] && nxt[idx];
  endfunction
endpackage

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int TAP0 = 7,
  parameter int TAP1 = 9,
  parameter int TAP2 = 11,
  parameter int TAP3 = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       stop_req,
  input  logic       clr_pend,
  input  logic [1:0] sel,
  output cnt_t       cnt,
  output logic       tap_rise
);
  logic inc_ok;
  int   tap_idx;

  assign inc_ok   = sub_tick && !stop_req && !clr_pend;
  assign tap_idx  = tap_index(sel, TAP0, TAP1, TAP2, TAP3);
  assign tap_rise = inc_ok && bit_rises(cnt, tap_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (stop_req)
      cnt <= '0;
    else if (sub_tick) begin
      if (clr_pend) cnt <= '0;
      else          cnt <= cnt + cnt_t'(1);
    end
  end
endmodule

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             sub_tick,
  input  logic             stop_req,
  input  logic             tap_rise,
  output logic [1:0]       sel,
  output logic             ie,
  output logic             flag,
  output logic             clr_pend
);
  logic flag_wclr;
  logic clr_req;

  assign flag_wclr = ctrl_we && !wdata[B_FLAG];
  assign clr_req   = ctrl_we && !wdata[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= 2'd0;
      ie  <= 1'b0;
    end else if (ctrl_we) begin
      sel <= {wdata[B_SEL1], wdata[B_SEL0]};
      ie  <= wdata[B_IE];
    end
  end

  // Set event has priority over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (tap_rise)  flag <= 1'b1;
    else if (flag_wclr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    clr_pend <= 1'b0;
    else if (clr_req)              clr_pend <= 1'b1;
    else if (sub_tick || stop_req) clr_pend <= 1'b0;
  end
endmodule

// File: rtl/subclk_watch_timer.sv
module subclk_watch_timer
  import wt_pkg::*;
#(
  parameter int TAP0 = 7,
  parameter int TAP1 = 9,
  parameter int TAP2 = 11,
  parameter int TAP3 = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_tick,
  input  logic             stop_req,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [15:0]      rdata,
  output logic             irq,
  output logic [CNT_W-1:0] wdog_count
);
  logic       ctrl_we;
  logic [1:0] sel;
  logic       ie;
  logic       flag;
  logic       clr_pend;
  logic       tap_rise;
  cnt_t       cnt;
  logic [REG_W-1:0] ctrl_rd;

  assign ctrl_we = wr_en && !addr;

  wt_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .wdata    (wdata),
    .sub_tick (sub_tick),
    .stop_req (stop_req),
    .tap_rise (tap_rise),
    .sel      (sel),
    .ie       (ie),
    .flag     (flag),
    .clr_pend (clr_pend)
  );

  wt_counter #(.TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sub_tick (sub_tick),
    .stop_req (stop_req),
    .clr_pend (clr_pend),
    .sel      (sel),
    .cnt      (cnt),
    .tap_rise (tap_rise)
  );

  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[B_SEL0] = sel[0];
    ctrl_rd[B_SEL1] = sel[1];
    ctrl_rd[B_IE]   = ie;
    ctrl_rd[B_CLR]  = !clr_pend;
    ctrl_rd[B_FLAG] = flag;
  end

  assign rdata      = addr ? {1'b0, cnt} : {8'h00, ctrl_rd};
  assign irq        = flag && ie;
  assign wdog_count = cnt;
endmodule

// File: rtl/wt_checker.sv
module wt_checker
  import wt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sub_tick,
  input logic             stop_req,
  input logic             ctrl_we,
  input logic [REG_W-1:0] wdata,
  input logic             clr_pend,
  input logic             tap_rise,
  input logic             flag,
  input logic             ie,
  input logic             irq,
  input cnt_t             cnt,
  input cnt_t             wdog_count
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_tick && !stop_req && !clr_pend) |=> cnt == $past(cnt) + cnt_t'(1));

  // R3
  stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> cnt == '0);

  // R4
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && sub_tick && !stop_req) |=> (cnt == '0) && !clr_pend);

  // R4
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && !sub_tick && !stop_req) |=> $stable(cnt));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_rise |=> flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(ctrl_we && !wdata[B_FLAG])) |=> flag);

  // R8
  irq_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie));

  // R9
  always_comb begin
    if (rst_n) begin
      wdog_match_chk: assert (wdog_count == cnt);
    end
  end
endmodule

bind subclk_watch_timer wt_checker u_wt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sub_tick   (sub_tick),
  .stop_req   (stop_req),
  .ctrl_we    (ctrl_we),
  .wdata      (wdata),
  .clr_pend   (clr_pend),
  .tap_rise   (tap_rise),
  .flag       (flag),
  .ie         (ie),
  .irq        (irq),
  .cnt        (cnt),
  .wdog_count (wdog_count)
);

// File: tb/test_subclk_watch_timer.sv
`timescale 1ns/1ps
module test_subclk_watch_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_tick = 1'b0;
  logic        stop_req = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [15:0] rdata;
  logic        irq;
  logic [14:0] wdog_count;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  subclk_watch_timer i_subclk_watch_timer (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .stop_req(stop_req),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .wdog_count(wdog_count)
  );

  // Control word: [1:0] sel, [2] ie, [3] clear (0 = clear), [4] flag (0 = clear)
  function automatic logic [7:0] cw(input logic [1:0] s, input logic e,
                                    input logic c, input logic f);
    return {3'b000, f, c, e, s};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk) sub_tick = 1'b1;
    repeat (n) @(negedge clk);
    sub_tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; addr = 1'b0; wdata = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    @(negedge clk) addr = a;
    #1 v = rdata;
  endtask

  task automatic fresh(input logic [1:0] s);
    wr(cw(s, 1'b0, 1'b0, 1'b0));
    run_ticks(1);
    wr(cw(s, 1'b0, 1'b1, 1'b0));
  endtask

  task automatic t_reset;
    rd(1'b0, rv); check("R2 ctrl", rv, 16'h0008);
    rd(1'b1, rv); check("R2 count", rv, 16'h0000);
    check("R2 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_count;
    run_ticks(37);
    rd(1'b1, rv); check("R1 count", rv, 16'd37);
    check("R9 wdog", {1'b0, wdog_count}, 16'd37);
  endtask

  task automatic t_clear;
    wr(cw(2'd0, 1'b0, 1'b0, 1'b1));
    rd(1'b0, rv); check("R4 pending bit", rv & 16'h0008, 16'h0000);
    rd(1'b1, rv); check("R4 hold", rv, 16'd37);
    run_ticks(1);
    rd(1'b1, rv); check("R4 cleared", rv, 16'd0);
    rd(1'b0, rv); check("R4 bit back", rv & 16'h0008, 16'h0008);
    run_ticks(3);
    rd(1'b1, rv); check("R4 resumes", rv, 16'd3);
  endtask

  task automatic t_stop;
    run_ticks(10);
    @(negedge clk) stop_req = 1'b1;
    run_ticks(5);
    rd(1'b1, rv); check("R3 stop", rv, 16'd0);
    @(negedge clk) stop_req = 1'b0;
    run_ticks(2);
    rd(1'b1, rv); check("R3 after stop", rv, 16'd2);
  endtask

  task automatic t_sel(input logic [1:0] s, input int bitn, input string tag);
    fresh(s);
    run_ticks((1 << bitn) - 1);
    rd(1'b0, rv); check({tag, " before"}, rv & 16'h0010, 16'h0000);
    run_ticks(1);
    rd(1'b0, rv); check({tag, " set"}, rv & 16'h0010, 16'h0010);
  endtask

  task automatic t_flag_sw;
    wr(cw(2'd0, 1'b0, 1'b1, 1'b1));
    rd(1'b0, rv); check("R6 write1 keeps", rv & 16'h0010, 16'h0010);
    wr(cw(2'd0, 1'b0, 1'b1, 1'b0));
    rd(1'b0, rv); check("R6 write0 clears", rv & 16'h0010, 16'h0000);
  endtask

  task automatic t_irq;
    fresh(2'd0);
    run_ticks(128);
    check("R8 irq off when ie=0", {15'd0, irq}, 16'd0);
    wr(cw(2'd0, 1'b1, 1'b1, 1'b1));
    check("R8 irq on", {15'd0, irq}, 16'd1);
    rd(1'b0, rv); check("R8 readback", rv, 16'h001C);
    wr(cw(2'd2, 1'b1, 1'b1, 1'b0));
    check("R8 irq off after clear", {15'd0, irq}, 16'd0);
    rd(1'b0, rv); check("R8 sel readback", rv, 16'h000E);
  endtask

  task automatic t_set_wins;
    fresh(2'd0);
    run_ticks(127);
    @(negedge clk) begin
      sub_tick = 1'b1; wr_en = 1'b1; addr = 1'b0; wdata = cw(2'd0, 1'b0, 1'b1, 1'b0);
    end
    @(negedge clk) begin sub_tick = 1'b0; wr_en = 1'b0; end
    rd(1'b0, rv); check("R7 set wins", rv & 16'h0010, 16'h0010);
  endtask

  task automatic t_wrap;
    fresh(2'd3);
    run_ticks(32767);
    rd(1'b1, rv); check("R1 max", rv, 16'h7FFF);
    run_ticks(1);
    rd(1'b1, rv); check("R1 wrap", rv, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_clear();
    t_stop();
    t_sel(2'd0, 7, "R5 sel0");
    t_flag_sw();
    t_sel(2'd1, 9, "R5 sel1");
    t_sel(2'd2, 11, "R5 sel2");
    t_sel(2'd3, 14, "R5 sel3");
    t_irq();
    t_set_wins();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule